// File: doc/BRIEF.md
# Double Fault Escalation Detector

This block sits beside an exception sequencer. It watches each raised event and the delivery of its handler. An event raised while no handler invocation is open is passed on unchanged. An event raised while a handler is being invoked is first sorted into one of three groups: benign, contributory, or page fault. The group of the event being invoked and the group of the new event then decide the result. The new event is either passed on normally or replaced by the double-fault vector.

If a contributory event or a page fault arrives while the double-fault handler is itself being invoked, the block raises a shutdown flag. The flag stays set until reset, and no further events are passed on. Descriptor lookup, error-code handling and handler fetch stay outside the block.

Every raise is answered one clock later with a single-cycle delivery pulse on the output side, unless shutdown is already set or is set by that raise.

Top module: `dfault_escalator`

## Requirements
- R1: After reset, `out_vld`, `out_dbl` and `shutdown` are 0, no event is tracked, and no invocation is open.
- R2: Classification. Vectors 0, 10, 11, 12 and 13 are contributory. Vector 14 is the page-fault group. Every other vector (1–9, 15–31 and 32–255) is benign. A raise with `raise_intr`=1 (software or external interrupt) is benign whatever its vector.
- R3: A raise while no invocation is open is delivered in the next cycle: `out_vld`=1, `out_vec` equal to the raised vector, and `out_dbl`=0. The raised event becomes the tracked event, with its invocation not yet open.
- R4: A contributory raise while a contributory event's invocation is open is delivered in the next cycle with `out_vec`=8 and `out_dbl`=1. The tracked event becomes the double fault, with its invocation not yet open.
- R5: A contributory or page-fault raise while a page fault's invocation is open escalates in the same way as R4 (`out_vec`=8, `out_dbl`=1).
- R6: Any other pairing with an open invocation delivers the new event normally, as in R3. This includes a benign raise during the double-fault invocation.
- R7: A contributory or page-fault raise while the double-fault invocation is open sets `shutdown` in the next cycle, with no delivery pulse. `shutdown` stays set until reset.
- R8: `dlv_start` opens the invocation of the tracked event, provided an event is tracked and no raise occurs in the same cycle. `dlv_done` returns the block to idle and closes the invocation. It takes effect before a raise in the same cycle, so that raise is judged as if the block were idle.
- R9: While `shutdown` is set, raises produce no delivery pulse.
- R10: `out_vld` and `out_dbl` are single-cycle pulses, present only in the cycle after a raise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Event raise strobe |
| raise_vec | input | 8 | Vector of the raised event |
| raise_intr | input | 1 | Raised event is a software or external interrupt (always benign) |
| dlv_start | input | 1 | Handler invocation for the tracked event begins |
| dlv_done | input | 1 | Handler invocation has completed |
| out_vld | output | 1 | Delivery pulse |
| out_vec | output | 8 | Vector to deliver |
| out_dbl | output | 1 | Delivered vector is an escalated double fault |
| shutdown | output | 1 | Sticky shutdown indication |

## Verification
The hardest state to reach from the ports is shutdown. It needs three steps in order: an escalating pair of raises, then a `dlv_start` that opens the double-fault invocation, then a third contributory or page-fault raise before any `dlv_done`. Random stimulus seldom lines these up. Directed sequences therefore build the chain explicitly, followed by random raises that confirm nothing is delivered afterwards. The random phase favours vectors 0, 10–14 and low-probability `dlv_done`, so open invocations last long enough for many class pairs to meet.

// File: rtl/dfault_escalator.sv
module dfault_escalator #(
  parameter int VEC_W  = 8,
  parameter int DF_VEC = 8,
  parameter int PF_VEC = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise_vld,
  input  logic [VEC_W-1:0] raise_vec,
  input  logic             raise_intr,
  input  logic             dlv_start,
  input  logic             dlv_done,
  output logic             out_vld,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_dbl,
  output logic             shutdown
);

  typedef enum logic [2:0] {C_IDLE, C_BEN, C_CON, C_PF, C_DF} cls_t;

  cls_t cls_q, cls_eff, cls_new;
  logic inv_q, inv_eff;
  logic sev_new, esc, kill;

  always_comb begin
    if (raise_intr)
      cls_new = C_BEN;
    else if (raise_vec == VEC_W'(PF_VEC))
      cls_new = C_PF;
    else if (raise_vec == '0 || (raise_vec >= VEC_W'(10) && raise_vec <= VEC_W'(13)))
      cls_new = C_CON;
    else
      cls_new = C_BEN;
  end

  assign cls_eff = dlv_done ? C_IDLE : cls_q;
  assign inv_eff = inv_q && !dlv_done;
  assign sev_new = (cls_new == C_CON) || (cls_new == C_PF);

  assign esc  = raise_vld && inv_eff &&
                ((cls_eff == C_CON && cls_new == C_CON) ||
                 (cls_eff == C_PF  && sev_new));
  assign kill = raise_vld && inv_eff && cls_eff == C_DF && sev_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_q    <= C_IDLE;
      inv_q    <= 1'b0;
      out_vld  <= 1'b0;
      out_vec  <= '0;
      out_dbl  <= 1'b0;
      shutdown <= 1'b0;
    end else begin
      out_vld <= 1'b0;
      out_dbl <= 1'b0;
      cls_q   <= cls_eff;
      inv_q   <= inv_eff;
      if (shutdown) begin
        inv_q <= 1'b0;
      end else if (kill) begin
        shutdown <= 1'b1;
        inv_q    <= 1'b0;
      end else if (esc) begin
        out_vld <= 1'b1;
        out_vec <= VEC_W'(DF_VEC);
        out_dbl <= 1'b1;
        cls_q   <= C_DF;
        inv_q   <= 1'b0;
      end else if (raise_vld) begin
        out_vld <= 1'b1;
        out_vec <= raise_vec;
        cls_q   <= cls_new;
        inv_q   <= 1'b0;
      end else if (dlv_start && cls_eff != C_IDLE) begin
        inv_q <= 1'b1;
      end
    end
  end

endmodule

module dfault_escalator_chk #(
  parameter int VEC_W  = 8,
  parameter int DF_VEC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             raise_vld,
  input logic             out_vld,
  input logic [VEC_W-1:0] out_vec,
  input logic             out_dbl,
  input logic             shutdown
);

  // R7
  shutdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);

  // R9
  no_dlv_in_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !out_vld);

  // R4
  dbl_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_dbl |-> (out_vld && out_vec == VEC_W'(DF_VEC)));

  // R10
  vld_after_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_vld == 1'b0 |=> !out_vld);

  // R10
  dbl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_dbl |=> !out_dbl || $past(raise_vld));

endmodule

bind dfault_escalator dfault_escalator_chk #(.VEC_W(VEC_W), .DF_VEC(DF_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .raise_vld(raise_vld), .out_vld(out_vld),
  .out_vec(out_vec), .out_dbl(out_dbl), .shutdown(shutdown));

// File: tb/dfault_escalator_tb.sv
module dfault_escalator_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raise_vld = 1'b0, raise_intr = 1'b0, dlv_start = 1'b0, dlv_done = 1'b0;
  logic [7:0] raise_vec = '0;
  logic out_vld, out_dbl, shutdown;
  logic [7:0] out_vec;

  int checks = 0, fails = 0;
  int m_cls = 0;   // 0 idle 1 benign 2 contrib 3 pf 4 df
  bit m_inv = 0, m_sd = 0;

  always #2 clk = ~clk;

  dfault_escalator dut_i (.*);

  function automatic int cls_of(logic [7:0] v, logic intr);
    if (intr) return 1;
    if (v == 8'd14) return 3;
    if (v == 8'd0 || (v >= 8'd10 && v <= 8'd13)) return 2;
    return 1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; raise_vld = 0; dlv_start = 0; dlv_done = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_cls = 0; m_inv = 0; m_sd = 0;
    chk("R1", "out_vld", out_vld, 0);
    chk("R1", "out_dbl", out_dbl, 0);
    chk("R1", "shutdown", shutdown, 0);
  endtask

  task automatic step(bit r, logic [7:0] v, bit intr, bit st, bit dn);
    int c, n, e_vec;
    bit e_vld, e_dbl, sev;
    string tag;
    @(negedge clk);
    raise_vld = r; raise_vec = v; raise_intr = intr; dlv_start = st; dlv_done = dn;
    c = dn ? 0 : m_cls;
    n = cls_of(v, intr);
    sev = (n == 2 || n == 3);
    e_vld = 0; e_dbl = 0; e_vec = -1;
    if (m_inv && dn) m_inv = 0;
    if (!r) tag = "R10"; else if (dn) tag = "R8"; else if (intr || v >= 32) tag = "R2"; else tag = "R3";
    if (m_sd) begin
      tag = "R9"; m_inv = 0;
    end else if (r && m_inv && c == 4 && sev) begin
      m_sd = 1; m_inv = 0; tag = "R7";
    end else if (r && m_inv && ((c == 2 && n == 2) || (c == 3 && sev))) begin
      e_vld = 1; e_dbl = 1; e_vec = 8; m_cls = 4; m_inv = 0;
      tag = (c == 3) ? "R5" : "R4";
    end else if (r) begin
      if (m_inv) tag = "R6";
      e_vld = 1; e_vec = v; m_cls = n; m_inv = 0;
    end else begin
      m_cls = c;
      if (st && c != 0) m_inv = 1;
    end
    @(posedge clk);
    #1;
    chk(tag, "out_vld", out_vld, e_vld);
    chk(tag, "out_dbl", out_dbl, e_dbl);
    chk(tag, "shutdown", shutdown, m_sd);
    if (e_vld) chk(tag, "out_vec", out_vec, e_vec);
    raise_vld = 0; dlv_start = 0; dlv_done = 0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    logic [7:0] rv;
    seed = 17;
    void'($urandom(seed));
    do_reset();
    // R3 then R4 then R7 then R9
    step(1, 13, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(1, 14, 0, 0, 0);
    step(1, 3, 0, 0, 0);
    step(1, 12, 0, 1, 1);
    do_reset();
    // R5, R8
    step(1, 14, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(1, 14, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(1, 3, 0, 0, 0);     // R6 benign during DF
    step(0, 0, 0, 1, 0);
    step(1, 10, 0, 0, 1);    // R8 done wins
    step(0, 0, 0, 1, 0);
    step(1, 11, 0, 0, 0);    // R4
    step(0, 0, 0, 0, 1);
    // R6 pairings
    step(1, 14, 0, 0, 0); step(0, 0, 0, 1, 0); step(1, 5, 0, 0, 0);
    step(1, 10, 0, 0, 0); step(0, 0, 0, 1, 0); step(1, 14, 0, 0, 0);
    // R2 interrupt flag and high vectors
    step(1, 0, 0, 0, 0); step(0, 0, 0, 1, 0); step(1, 0, 1, 0, 0);
    step(1, 12, 0, 0, 0); step(0, 0, 0, 1, 0); step(1, 200, 0, 0, 0);
    step(1, 13, 0, 0, 0); step(1, 13, 0, 0, 0);  // R3 not yet opened
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < 4000; i++) begin
      if (i % 700 == 699) do_reset();
      case ($urandom_range(0, 5))
        0: rv = 8'd0;
        1: rv = 8'(10 + $urandom_range(0, 3));
        2: rv = 8'd14;
        3: rv = 8'($urandom_range(32, 255));
        default: rv = 8'($urandom_range(1, 31));
      endcase
      step($urandom_range(0, 2) == 0, rv, $urandom_range(0, 7) == 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule